// File: doc/BRIEF.md
# Decoder Status, Interrupt and Block-Count Control

This block is the host-facing control and status unit of a block-based image decoder. An 8-bit host bus with a 4-bit address reaches five locations. A control register carries three command bits that act once and clear themselves, plus a marker-handling enable and three interrupt enables. A read-only status register shows three busy bits, an error flag, an input-FIFO low-level flag and a block-ready flag. A data port forwards bytes to the input FIFO, and a pixel port reads bytes from the output buffer. The block-count location reaches a 24-bit down-counter as three bytes in a row.

The decoding datapath is outside this block. It reports to the block through event inputs: a block finished, a resynchronisation marker with its low three bits, a code error, the input-FIFO occupancy and an output-block-available pulse. Each of the three flags is cleared by the host access that naturally follows it. The FIFO-low flag clears on a FIFO data write. The block-ready flag clears on a pixel read. The error flag clears once the host has read all three bytes of the block counter.

When marker handling is on, a marker is expected only when the counter has reached zero. A marker that arrives early is an error. After such an error the decoder is held until the next marker. While the error flag is set, the busy bits of the status register show the index of the last accepted marker instead.

Top module: `dec_ctrl`

## Requirements
- R1: Every host access (cs with rd or wr) is answered by `ready` high for exactly the next clock. A read returns its byte on `rdata` in that same cycle, and `rdata` is zero in every other cycle.
- R2: The control register is at address 0. Bit 0 starts decoding, bit 1 clears the input FIFO and bit 2 is a soft reset; each pulses its output (`start_o`, `fifo_clr_o`, `srst_o`) for one clock after the write and reads back as 0. Bit 3 enables marker handling, and bits 4, 5 and 6 enable the error, FIFO-low and block-ready interrupts; these are stored and read back.
- R3: `irq` is high exactly when at least one flag is set together with its enable bit.
- R4: The block counter is at address 2. Successive accesses there step through bytes most significant first, and the pointer wraps after the third byte. The third write loads the counter. The first read returns the live top byte and freezes the lower two bytes for the reads that follow.
- R5: Each `blk_done` pulse decrements a non-zero counter. The counter holds at zero and does not change while decoding is held.
- R6: The FIFO-low flag (status bit 4) sets in any cycle where `fifo_level` is at or below a quarter of the FIFO depth. A write to address 3 clears it, and the clear wins in that cycle. The write is forwarded on `fifo_wr_o`/`fifo_wdata_o` one clock later.
- R7: The block-ready flag (status bit 5, also `blk_rdy_o`) sets on `blk_avail`. A read of address 4 clears it and returns `pix_data`.
- R8: The error flag (status bit 3) clears only on the read of the third counter byte, or on soft reset.
- R9: With marker handling on, a marker that arrives while the counter is non-zero sets the error flag. A marker that arrives with the counter at zero reloads the counter from the last value written.
- R10: Status bits 2:0 show {`dct_busy`,`qzt_busy`,`vlc_busy`}. While the error flag is set they show instead the index of the last accepted marker.
- R11: An error (marker or `code_err`) with marker handling on raises `dec_hold`, which stays high until the next marker. With marker handling off, an error does not raise `dec_hold`.
- R12: With marker handling off, markers have no effect on the counter or the error flag.
- R13: Soft reset clears all three flags, `dec_hold`, the byte pointer and the marker index. It keeps the counter, its reload value and the control enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Host select |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| addr | input | 4 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid with ready |
| ready | output | 1 | One-cycle access response |
| vlc_busy | input | 1 | Entropy decoder busy |
| qzt_busy | input | 1 | Dequantiser busy |
| dct_busy | input | 1 | Inverse transform busy |
| blk_done | input | 1 | One block decoded |
| code_err | input | 1 | Datapath code error |
| mark_seen | input | 1 | Resynchronisation marker found |
| mark_idx | input | 3 | Low three bits of that marker |
| fifo_level | input | LVL_W | Input FIFO occupancy |
| blk_avail | input | 1 | Output block available |
| pix_data | input | 8 | Output buffer byte |
| irq | output | 1 | Interrupt request |
| start_o | output | 1 | Start pulse |
| fifo_clr_o | output | 1 | Input FIFO clear pulse |
| srst_o | output | 1 | Soft reset pulse |
| fifo_wr_o | output | 1 | Input FIFO write strobe |
| fifo_wdata_o | output | 8 | Input FIFO write byte |
| pix_rd_o | output | 1 | Output buffer read strobe |
| dec_hold | output | 1 | Decoding held until next marker |
| blk_rdy_o | output | 1 | Block-ready flag |

## Verification
The bench builds the block with the default 24-bit counter and a FIFO depth of 16. That depth puts the low-level threshold at 4, so the bench can sweep the level across it with small values. A three-byte counter makes the pointer wrap and the frozen lower bytes visible: the bench loads values such as 0x123456 and abandons a readout partway through before a soft reset. Short counts of 1 to 3 blocks let the marker sequence reach zero, reload, fire the mismatch error, hold decoding and resume, all within a few dozen cycles.

// File: rtl/dec_ctrl_pkg.sv
package dec_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h1;
  localparam logic [ADDR_W-1:0] A_NBLK = 4'h2;
  localparam logic [ADDR_W-1:0] A_FIFO = 4'h3;
  localparam logic [ADDR_W-1:0] A_PIX  = 4'h4;

  // control register bit positions
  localparam int C_START  = 0;
  localparam int C_FCLR   = 1;
  localparam int C_SRST   = 2;
  localparam int C_MEN    = 3;
  localparam int C_IE_ERR = 4;
  localparam int C_IE_LOW = 5;
  localparam int C_IE_BLK = 6;
  localparam int NCMD     = 3;
  localparam int CTRL_W   = 7;

  typedef struct packed {
    logic blk;
    logic low;
    logic err;
  } flag_t;
endpackage

// File: rtl/dec_hostif.sv
module dec_hostif
  import dec_ctrl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     ctrl_rb,
  input  logic [DW-1:0]     stat_rb,
  input  logic [DW-1:0]     nblk_rb,
  input  logic [DW-1:0]     pix_data,
  output logic              wr_ctrl,
  output logic              wr_nblk,
  output logic              rd_nblk,
  output logic              wr_fifo,
  output logic              rd_pix,
  output logic              ready,
  output logic [DW-1:0]     rdata,
  output logic              fifo_wr_o,
  output logic [DW-1:0]     fifo_wdata_o,
  output logic              pix_rd_o
);
  logic do_wr, do_rd;
  logic [DW-1:0] rd_mux;

  assign do_wr = cs & wr;
  assign do_rd = cs & rd & ~wr;

  always_comb begin
    wr_ctrl = do_wr && (addr == A_CTRL);
    wr_nblk = do_wr && (addr == A_NBLK);
    wr_fifo = do_wr && (addr == A_FIFO);
    rd_nblk = do_rd && (addr == A_NBLK);
    rd_pix  = do_rd && (addr == A_PIX);
  end

  always_comb begin
    rd_mux = '0;
    if (do_rd) begin
      case (addr)
        A_CTRL:  rd_mux = ctrl_rb;
        A_STAT:  rd_mux = stat_rb;
        A_NBLK:  rd_mux = nblk_rb;
        A_PIX:   rd_mux = pix_data;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready        <= 1'b0;
      rdata        <= '0;
      fifo_wr_o    <= 1'b0;
      fifo_wdata_o <= '0;
      pix_rd_o     <= 1'b0;
    end else begin
      ready     <= do_wr | do_rd;
      rdata     <= rd_mux;
      fifo_wr_o <= wr_fifo;
      pix_rd_o  <= rd_pix;
      if (wr_fifo) fifo_wdata_o <= wdata;
    end
  end
endmodule

// File: rtl/dec_cmdreg.sv
module dec_cmdreg
  import dec_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctrl,
  input  logic [CTRL_W-1:0] wbits,
  output logic [NCMD-1:0] cmd_o,
  output logic            men,
  output flag_t           ie
);
  // one self-clearing pulse register per command bit
  for (genvar g = 0; g < NCMD; g++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (rst) cmd_o[g] <= 1'b0;
      else     cmd_o[g] <= wr_ctrl & wbits[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      men <= 1'b0;
      ie  <= '0;
    end else if (wr_ctrl) begin
      men    <= wbits[C_MEN];
      ie.err <= wbits[C_IE_ERR];
      ie.low <= wbits[C_IE_LOW];
      ie.blk <= wbits[C_IE_BLK];
    end
  end
endmodule

// File: rtl/dec_blkcnt.sv
module dec_blkcnt #(
  parameter int CNT_W = 24,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             men,
  input  logic             wr_nblk,
  input  logic             rd_nblk,
  input  logic [DW-1:0]    wdata,
  input  logic             blk_done,
  input  logic             code_err,
  input  logic             mark_seen,
  input  logic [2:0]       mark_idx,
  output logic [DW-1:0]    nblk_rb,
  output logic             err,
  output logic             hold,
  output logic [2:0]       last_mark,
  output logic [CNT_W-1:0] cnt
);
  localparam int NB    = CNT_W / DW;
  localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1;

  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] rel, rel_wr, snap;
  logic             last_byte, cnt_zero, mark_ev, good, bad, err_set, rdout_done;
  int               sh;

  always_comb begin
    last_byte  = (ptr == PTR_W'(NB - 1));
    cnt_zero   = (cnt == '0);
    mark_ev    = men & mark_seen;
    good       = mark_ev & (hold | cnt_zero);
    bad        = mark_ev & ~hold & ~cnt_zero;
    err_set    = bad | code_err;
    rdout_done = rd_nblk & last_byte;
    sh         = DW * (NB - 1 - int'(ptr));
    rel_wr     = rel;
    rel_wr[sh +: DW] = wdata;
    if (ptr == '0) nblk_rb = cnt[CNT_W-1 -: DW];
    else           nblk_rb = snap[sh +: DW];
  end

  // byte pointer, reload value and read snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      rel  <= '0;
      snap <= '0;
    end else begin
      if (srst)                        ptr <= '0;
      else if (wr_nblk | rd_nblk)      ptr <= last_byte ? '0 : ptr + 1'b1;
      if (wr_nblk)                     rel <= rel_wr;
      if (rd_nblk && ptr == '0)        snap <= cnt;
    end
  end

  // down-counter
  always_ff @(posedge clk) begin
    if (rst)                                 cnt <= '0;
    else if (wr_nblk & last_byte)            cnt <= rel_wr;
    else if (good)                           cnt <= rel;
    else if (blk_done & ~hold & ~cnt_zero)   cnt <= cnt - 1'b1;
  end

  // error flag, hold state and marker index
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      err       <= 1'b0;
      hold      <= 1'b0;
      last_mark <= '0;
    end else begin
      if (err_set)         err <= 1'b1;
      else if (rdout_done) err <= 1'b0;
      if (err_set & men)   hold <= 1'b1;
      else if (good)       hold <= 1'b0;
      if (good)            last_mark <= mark_idx;
    end
  end
endmodule

// File: rtl/dec_flags.sv
module dec_flags
  import dec_ctrl_pkg::*;
#(
  parameter int LVL_W = 7,
  parameter int THR   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             wr_fifo,
  input  logic             rd_pix,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             blk_avail,
  input  logic             err,
  input  flag_t            ie,
  output logic             low,
  output logic             blk,
  output logic             irq
);
  logic lvl_low;
  flag_t fl;

  assign lvl_low = (fifo_level <= LVL_W'(THR));

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      low <= 1'b0;
      blk <= 1'b0;
    end else begin
      if (wr_fifo)      low <= 1'b0;
      else if (lvl_low) low <= 1'b1;
      if (blk_avail)    blk <= 1'b1;
      else if (rd_pix)  blk <= 1'b0;
    end
  end

  always_comb begin
    fl.blk = blk;
    fl.low = low;
    fl.err = err;
    irq    = |(fl & ie);
  end
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_ctrl_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  input  logic              vlc_busy,
  input  logic              qzt_busy,
  input  logic              dct_busy,
  input  logic              blk_done,
  input  logic              code_err,
  input  logic              mark_seen,
  input  logic [2:0]        mark_idx,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              blk_avail,
  input  logic [DATA_W-1:0] pix_data,
  output logic              irq,
  output logic              start_o,
  output logic              fifo_clr_o,
  output logic              srst_o,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              pix_rd_o,
  output logic              dec_hold,
  output logic              blk_rdy_o
);
  localparam int THR = FIFO_DEPTH / 4;

  logic              wr_ctrl, wr_nblk, rd_nblk, wr_fifo, rd_pix, srst_now;
  logic [NCMD-1:0]   cmd;
  logic              men;
  flag_t             ie;
  logic              err_q, low_q;
  logic [2:0]        last_mark;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] ctrl_rb, stat_rb, nblk_rb;

  assign srst_now = wr_ctrl & wdata[C_SRST];
  assign ctrl_rb  = {1'b0, ie.blk, ie.low, ie.err, men, 3'b000};
  assign stat_rb  = {2'b00, blk_rdy_o, low_q, err_q,
                     err_q ? last_mark : {dct_busy, qzt_busy, vlc_busy}};

  assign start_o    = cmd[C_START];
  assign fifo_clr_o = cmd[C_FCLR];
  assign srst_o     = cmd[C_SRST];

  dec_hostif #(.DW(DATA_W)) u_host (
    .clk, .rst, .cs, .rd, .wr, .addr, .wdata,
    .ctrl_rb, .stat_rb, .nblk_rb, .pix_data,
    .wr_ctrl, .wr_nblk, .rd_nblk, .wr_fifo, .rd_pix,
    .ready, .rdata, .fifo_wr_o, .fifo_wdata_o, .pix_rd_o
  );

  dec_cmdreg u_cmd (
    .clk, .rst, .wr_ctrl,
    .wbits (wdata[CTRL_W-1:0]),
    .cmd_o (cmd),
    .men, .ie
  );

  dec_blkcnt #(.CNT_W(CNT_W), .DW(DATA_W)) u_cnt (
    .clk, .rst,
    .srst      (srst_now),
    .men, .wr_nblk, .rd_nblk, .wdata, .blk_done, .code_err,
    .mark_seen, .mark_idx, .nblk_rb,
    .err       (err_q),
    .hold      (dec_hold),
    .last_mark,
    .cnt       (cnt_q)
  );

  dec_flags #(.LVL_W(LVL_W), .THR(THR)) u_flg (
    .clk, .rst,
    .srst    (srst_now),
    .wr_fifo, .rd_pix, .fifo_level, .blk_avail,
    .err     (err_q),
    .ie,
    .low     (low_q),
    .blk     (blk_rdy_o),
    .irq
  );
endmodule

// File: rtl/dec_ctrl_chk.sv
module dec_ctrl_chk
  import dec_ctrl_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ready,
  input logic              start_o,
  input logic              blk_avail,
  input logic              blk_rdy_o,
  input logic              err_q,
  input logic              low_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              dec_hold,
  input logic              mark_seen,
  input logic              blk_done
);
  assert_ready_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (cs && (rd || wr)) |=> ready);

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !(cs && (rd || wr)) |=> !ready);

  assert_start_only_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr && addr == A_CTRL) |=> !start_o);

  assert_fifo_write_clears_low_R6: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == A_FIFO) |=> !low_q);

  assert_pix_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !wr && addr == A_PIX && !blk_avail) |=> !blk_rdy_o);

  assert_err_clear_source_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> ($past(cs && rd && !wr && addr == A_NBLK) ||
                      $past(cs && wr && addr == A_CTRL && wdata[C_SRST])));

  assert_hold_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (dec_hold && !mark_seen && !(cs && wr && addr == A_CTRL)) |=> dec_hold);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (blk_done && !dec_hold && cnt_q != '0 && !mark_seen && !(cs && wr && addr == A_NBLK))
      |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

bind dec_ctrl dec_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs        (cs),
  .rd        (rd),
  .wr        (wr),
  .addr      (addr),
  .wdata     (wdata),
  .ready     (ready),
  .start_o   (start_o),
  .blk_avail (blk_avail),
  .blk_rdy_o (blk_rdy_o),
  .err_q     (err_q),
  .low_q     (low_q),
  .cnt_q     (cnt_q),
  .dec_hold  (dec_hold),
  .mark_seen (mark_seen),
  .blk_done  (blk_done)
);

// File: tb/sim_dec_ctrl.sv
`timescale 1ns/1ps
module sim_dec_ctrl;
  localparam int CNT_W = 24;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, rd = 0, wr = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ready;
  logic vlc_busy = 0, qzt_busy = 0, dct_busy = 0;
  logic blk_done = 0, code_err = 0, mark_seen = 0;
  logic [2:0] mark_idx = 0;
  logic [LVL_W-1:0] fifo_level = LVL_W'(16);
  logic blk_avail = 0;
  logic [7:0] pix_data = 0;
  logic irq, start_o, fifo_clr_o, srst_o, fifo_wr_o, pix_rd_o, dec_hold, blk_rdy_o;
  logic [7:0] fifo_wdata_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dec_ctrl #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) u0 (
    .clk, .rst, .cs, .rd, .wr, .addr, .wdata, .rdata, .ready,
    .vlc_busy, .qzt_busy, .dct_busy, .blk_done, .code_err, .mark_seen,
    .mark_idx, .fifo_level, .blk_avail, .pix_data, .irq, .start_o,
    .fifo_clr_o, .srst_o, .fifo_wr_o, .fifo_wdata_o, .pix_rd_o,
    .dec_hold, .blk_rdy_o
  );

  // ---------------- behavioural reference model ----------------
  bit m_ready, m_start, m_fclr, m_srst, m_fwr, m_prd;
  bit [7:0] m_rdata, m_fwd;
  bit m_men, m_iee, m_iel, m_ieb;
  bit m_err, m_low, m_blk, m_hold;
  bit [2:0] m_last;
  int m_cnt, m_rel, m_snap, m_ptr;

  always @(posedge clk) begin
    bit dw, dr, ev, good, bad, eset, sr, lastb;
    int nrel;
    bit [7:0] rv;
    if (rst) begin
      m_ready = 0; m_start = 0; m_fclr = 0; m_srst = 0; m_fwr = 0; m_prd = 0;
      m_rdata = 0; m_fwd = 0; m_men = 0; m_iee = 0; m_iel = 0; m_ieb = 0;
      m_err = 0; m_low = 0; m_blk = 0; m_hold = 0; m_last = 0;
      m_cnt = 0; m_rel = 0; m_snap = 0; m_ptr = 0;
    end else begin
      dw = cs && wr;
      dr = cs && rd && !wr;
      rv = 0;
      if (dr) begin
        if (addr == 0) rv = {1'b0, m_ieb, m_iel, m_iee, m_men, 3'b000};
        else if (addr == 1) rv = {2'b00, m_blk, m_low, m_err,
                                  m_err ? m_last : {dct_busy, qzt_busy, vlc_busy}};
        else if (addr == 2) rv = (m_ptr == 0) ? 8'((m_cnt >> 16) & 255)
                                              : 8'((m_snap >> (8 * (2 - m_ptr))) & 255);
        else if (addr == 4) rv = pix_data;
      end
      lastb = (m_ptr == 2);
      ev    = m_men && mark_seen;
      good  = ev && (m_hold || m_cnt == 0);
      bad   = ev && !m_hold && m_cnt != 0;
      eset  = bad || code_err;
      sr    = dw && addr == 0 && wdata[2];
      nrel  = m_rel;
      if (dw && addr == 2)
        nrel = (m_rel & ~(255 << (8 * (2 - m_ptr)))) | (int'(wdata) << (8 * (2 - m_ptr)));
      // counter
      if (dw && addr == 2 && lastb) m_cnt = nrel;
      else if (good) m_cnt = m_rel;
      else if (blk_done && !m_hold && m_cnt != 0) m_cnt = m_cnt - 1;
      if (dr && addr == 2 && m_ptr == 0) m_snap = m_cnt;
      m_rel = nrel;
      // error / hold / marker
      if (sr) begin
        m_err = 0; m_hold = 0; m_last = 0;
      end else begin
        if (eset && m_men) m_hold = 1;
        else if (good) m_hold = 0;
        if (eset) m_err = 1;
        else if (dr && addr == 2 && lastb) m_err = 0;
        if (good) m_last = mark_idx;
      end
      // pointer
      if (sr) m_ptr = 0;
      else if ((dw || dr) && addr == 2) m_ptr = lastb ? 0 : m_ptr + 1;
      // flags
      if (sr) begin
        m_low = 0; m_blk = 0;
      end else begin
        if (dw && addr == 3) m_low = 0;
        else if (fifo_level <= LVL_W'(DEPTH / 4)) m_low = 1;
        if (blk_avail) m_blk = 1;
        else if (dr && addr == 4) m_blk = 0;
      end
      // control register and registered outputs
      m_start = dw && addr == 0 && wdata[0];
      m_fclr  = dw && addr == 0 && wdata[1];
      m_srst  = sr;
      if (dw && addr == 0) begin
        m_men = wdata[3]; m_iee = wdata[4]; m_iel = wdata[5]; m_ieb = wdata[6];
      end
      m_ready = dw || dr;
      m_rdata = rv;
      m_fwr   = dw && addr == 3;
      if (dw && addr == 3) m_fwd = wdata;
      m_prd   = dr && addr == 4;
    end
  end

  // per-clock comparison against the model (R1 R2 R3 R6 R7 R11)
  always @(negedge clk) begin
    logic [22:0] got, exp;
    if (!rst) begin
      got = {ready, rdata, irq, start_o, fifo_clr_o, srst_o, fifo_wr_o, fifo_wdata_o[3:0],
             pix_rd_o, dec_hold, blk_rdy_o, 1'b0};
      exp = {m_ready, m_rdata,
             (m_err & m_iee) | (m_low & m_iel) | (m_blk & m_ieb),
             m_start, m_fclr, m_srst, m_fwr, m_fwd[3:0], m_prd, m_hold, m_blk, 1'b0};
      checks++;
      if (got !== exp || fifo_wdata_o !== m_fwd) begin
        failures++;
        $display("FAIL R1 R2 R3 R6 R7 R11 model compare: got %h exp %h (fifo byte %h/%h)",
                 got, exp, fifo_wdata_o, m_fwd);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; wdata = 0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    cs = 1; rd = 1; wr = 0; addr = a;
    @(negedge clk);
    d = rdata;
    cs = 0; rd = 0;
  endtask

  task automatic pulse_blk_done();
    blk_done = 1; @(negedge clk); blk_done = 0;
  endtask

  task automatic pulse_mark(input logic [2:0] idx);
    mark_seen = 1; mark_idx = idx; @(negedge clk); mark_seen = 0;
  endtask

  task automatic rd_cnt(input string tag, input logic [23:0] exp);
    logic [7:0] b;
    host_rd(4'h2, b); chk(tag, b, exp[23:16]);
    host_rd(4'h2, b); chk(tag, b, exp[15:8]);
    host_rd(4'h2, b); chk(tag, b, exp[7:0]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("R13 reset irq/hold/blk", {5'b0, irq, dec_hold, blk_rdy_o}, 8'h00);
    host_rd(4'h1, b); chk("R10 status idle", b, 8'h00);
    chk("R1 ready with read", {7'b0, ready}, 8'h01);
    @(negedge clk);
    chk("R1 ready drops", {7'b0, ready}, 8'h00);
    {dct_busy, qzt_busy, vlc_busy} = 3'b101;
    host_rd(4'h1, b); chk("R10 busy bits", b, 8'h05);

    // self-clearing commands
    host_wr(4'h0, 8'h01);
    chk("R2 start pulse", {7'b0, start_o}, 8'h01);
    @(negedge clk);
    chk("R2 start cleared", {7'b0, start_o}, 8'h00);
    host_wr(4'h0, 8'h02);
    chk("R2 fifo clear pulse", {7'b0, fifo_clr_o}, 8'h01);
    host_rd(4'h0, b); chk("R2 command bits read zero", b, 8'h00);

    // block counter load and count-down
    host_wr(4'h2, 8'h00); host_wr(4'h2, 8'h00); host_wr(4'h2, 8'h03);
    rd_cnt("R4 counter readback", 24'h000003);
    pulse_blk_done(); pulse_blk_done();
    rd_cnt("R5 decrement", 24'h000001);
    pulse_blk_done(); pulse_blk_done(); pulse_blk_done();
    rd_cnt("R5 hold at zero", 24'h000000);

    // markers
    host_wr(4'h0, 8'h18);
    host_rd(4'h0, b); chk("R2 enables readback", b, 8'h18);
    pulse_mark(3'd5);
    chk("R9 good marker no error", {6'b0, irq, dec_hold}, 8'h00);
    rd_cnt("R9 reload on marker", 24'h000003);
    pulse_mark(3'd6);
    chk("R9 R11 early marker error + hold", {6'b0, irq, dec_hold}, 8'h03);
    {dct_busy, qzt_busy, vlc_busy} = 3'b010;
    host_rd(4'h1, b); chk("R10 busy replaced by marker index", b, 8'h0D);
    pulse_blk_done();
    host_rd(4'h2, b); chk("R5 frozen while held", b, 8'h00);
    host_rd(4'h2, b); chk("R8 partial readout", b, 8'h00);
    chk("R8 error kept after two bytes", {7'b0, irq}, 8'h01);
    host_rd(4'h2, b); chk("R5 frozen while held low byte", b, 8'h03);
    chk("R8 error cleared after full readout", {7'b0, irq}, 8'h00);
    chk("R11 still held", {7'b0, dec_hold}, 8'h01);
    host_rd(4'h1, b); chk("R10 busy restored", b, 8'h02);
    pulse_mark(3'd2);
    chk("R11 released by marker", {7'b0, dec_hold}, 8'h00);

    // markers disabled
    host_wr(4'h0, 8'h10);
    pulse_mark(3'd1);
    chk("R12 marker ignored", {6'b0, irq, dec_hold}, 8'h00);
    rd_cnt("R12 count unchanged", 24'h000003);

    // FIFO low flag
    host_wr(4'h0, 8'h30);
    fifo_level = LVL_W'(4);
    @(negedge clk);
    chk("R6 R3 low flag raises irq", {7'b0, irq}, 8'h01);
    fifo_level = LVL_W'(10);
    @(negedge clk);
    chk("R6 low flag sticky", {7'b0, irq}, 8'h01);
    host_wr(4'h3, 8'hA5);
    chk("R6 fifo write strobe", {7'b0, fifo_wr_o}, 8'h01);
    chk("R6 fifo write data", fifo_wdata_o, 8'hA5);
    chk("R6 low cleared by write", {7'b0, irq}, 8'h00);

    // block ready
    host_wr(4'h0, 8'h00);
    blk_avail = 1; @(negedge clk); blk_avail = 0;
    chk("R3 flag without enable", {6'b0, irq, blk_rdy_o}, 8'h01);
    host_wr(4'h0, 8'h40);
    chk("R3 enable raises irq", {7'b0, irq}, 8'h01);
    pix_data = 8'h3C;
    host_rd(4'h4, b); chk("R7 pixel byte", b, 8'h3C);
    chk("R7 pixel read clears flag", {6'b0, irq, blk_rdy_o}, 8'h00);

    // soft reset
    host_wr(4'h0, 8'h00);
    blk_avail = 1; @(negedge clk); blk_avail = 0;
    code_err = 1; @(negedge clk); code_err = 0;
    chk("R11 no hold when markers off", {7'b0, dec_hold}, 8'h00);
    host_rd(4'h1, b); chk("R10 R7 status with error", b, 8'h2A);
    host_wr(4'h2, 8'h12); host_wr(4'h2, 8'h34); host_wr(4'h2, 8'h56);
    host_rd(4'h2, b); chk("R4 top byte", b, 8'h12);
    host_wr(4'h0, 8'h44);
    chk("R2 soft reset pulse", {7'b0, srst_o}, 8'h01);
    host_rd(4'h1, b); chk("R13 flags cleared", b, 8'h02);
    host_rd(4'h0, b); chk("R13 enables kept", b, 8'h40);
    rd_cnt("R13 count kept, pointer reset", 24'h123456);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule